// File: doc/BRIEF.md
# Automatic Acknowledgment Frame Generator

This block sits behind a receive frame filter in a low-rate wireless packet engine. When the filter signals that a frame was accepted, the block decides from the frame's control field and its own configuration whether the sender expects an acknowledgment. If one is owed, it writes a four-byte acknowledgment (length, two control bytes, sequence number) through a byte-wide transmit buffer write port. The checksum is appended further down the transmit path.

After writing the frame it waits a turnaround time counted in microsecond ticks. The time is a base delay plus an extension. The extension is read only at the moment the base part runs out, so firmware may still adjust it during the base count to align with slot boundaries. The block then strobes a transmit request and waits for the radio to report completion. It then pulses a packet-sent flag and returns to ready. Receive events that arrive while it is busy are dropped.

Top module: `autoack_engine`

## Requirements
- R1: No acknowledgment is produced unless `cfg_ack_en` is 1 and `cfg_promisc` is 0; otherwise an accept pulse causes no buffer write and no transmit strobe, and `ready` stays 1.
- R2: With the block enabled, an accepted frame is acknowledged only if its frame type `rx_fcf[2:0]` is neither 0 (beacon) nor 2 (acknowledgment) and its request bit `rx_fcf[5]` is 1.
- R3: The acknowledgment is written as exactly four buffer writes to addresses 0, 1, 2, 3 in that order, carrying 5, the control low byte, 0x00 and the received sequence number.
- R4: The control low byte is 0x12 (pending bit 4 set) when `rx_is_datareq` and `cfg_pend` are both 1, and 0x02 in every other case.
- R5: `tx_start` is a single-cycle strobe, raised only after exactly `cfg_base_dly` + extension `us_tick` pulses have been counted following the last buffer write.
- R6: The extension value is taken from `cfg_ext_dly` at the moment the base count ends; changes before that moment take effect, changes after it do not.
- R7: A `tx_done` pulse while waiting for transmission gives a one-cycle `pkt_sent` pulse in the next cycle, with `ready` returning to 1 in that same cycle.
- R8: While `ready` is 0, further `rx_accept` pulses are ignored: they cause no extra buffer write and no extra transmit strobe, and do not alter the frame being sent.
- R9: After reset `ready` is 1 and `tx_start`, `pkt_sent` and `buf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cfg_ack_en | input | 1 | Automatic acknowledgment enable |
| cfg_promisc | input | 1 | Accept-all-addresses mode; disables acknowledgment |
| cfg_pend | input | 1 | Value for the pending bit in replies to data requests |
| cfg_base_dly | input | DW | Base turnaround delay in ticks |
| cfg_ext_dly | input | DW | Extension delay in ticks, read when base ends |
| rx_accept | input | 1 | Filter accepted a frame (pulse) |
| rx_fcf | input | 16 | Frame control field of the accepted frame |
| rx_seq | input | 8 | Sequence number of the accepted frame |
| rx_is_datareq | input | 1 | Accepted frame is a data-request command |
| buf_we | output | 1 | Transmit buffer write enable |
| buf_addr | output | AW | Transmit buffer byte address |
| buf_wdata | output | 8 | Transmit buffer write data |
| tx_start | output | 1 | Transmit request strobe |
| tx_done | input | 1 | Radio reports transmission finished |
| pkt_sent | output | 1 | Acknowledgment sent (pulse) |
| ready | output | 1 | Idle and able to take a new frame |

## Verification
The delicate coincidence is a firmware update of the extension delay against the cycle in which the base count expires and the extension is captured. The bench rewrites `cfg_ext_dly` once shortly after the accept pulse, well before expiry, and once after the first extension tick has been counted. It judges the outcome by counting the `us_tick` pulses between the last buffer write and `tx_start`, which must equal the base plus the early value. A second overlap, a fresh accept pulse landing during the turnaround, is judged by the total write and strobe counts and by the sequence byte left in the modelled buffer.

// File: rtl/autoack_pkg.sv
package autoack_pkg;
  localparam int ACK_BYTES = 4;
  localparam int IDX_W     = $clog2(ACK_BYTES);

  localparam logic [2:0] FT_BEACON  = 3'd0;
  localparam logic [2:0] FT_ACK     = 3'd2;
  localparam int         REQ_BIT    = 5;
  localparam int         PEND_BIT   = 4;
  localparam logic [7:0] ACK_LEN    = 8'd5;
  localparam logic [7:0] ACK_FCF_LO = 8'h02;
  localparam logic [7:0] ACK_FCF_HI = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUILD  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_TXWAIT = 2'd3
  } ack_state_e;
endpackage

// File: rtl/ack_rules.sv
module ack_rules
  import autoack_pkg::*;
(
  input  logic        en,
  input  logic        promisc,
  input  logic        pend_cfg,
  input  logic [15:0] fcf,
  input  logic        is_datareq,
  output logic        want_ack,
  output logic        pend
);
  logic [2:0] ftype;

  always_comb begin
    ftype    = fcf[2:0];
    want_ack = en && !promisc && fcf[REQ_BIT] &&
               (ftype != FT_BEACON) && (ftype != FT_ACK);
    pend     = pend_cfg && is_datareq;
  end
endmodule

// File: rtl/ack_writer.sv
module ack_writer
  import autoack_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [7:0]    seq,
  input  logic          pend,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          last
);
  logic [IDX_W-1:0] idx;
  logic [7:0]       byte_val;

  always_comb begin
    case (idx)
      2'd0:    byte_val = ACK_LEN;
      2'd1:    byte_val = ACK_FCF_LO | (pend ? (8'd1 << PEND_BIT) : 8'd0);
      2'd2:    byte_val = ACK_FCF_HI;
      default: byte_val = seq;
    endcase
    last = go && (idx == IDX_W'(ACK_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
    end else if (go) begin
      buf_we    <= 1'b1;
      buf_addr  <= AW'(idx);
      buf_wdata <= byte_val;
      idx       <= last ? '0 : idx + 1'b1;
    end else begin
      buf_we <= 1'b0;
      idx    <= '0;
    end
  end
endmodule

// File: rtl/ack_turnaround.sv
module ack_turnaround #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] ext,
  output logic          done
);
  logic          in_ext;
  logic [DW-1:0] rem;

  assign done = run && in_ext && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ext <= 1'b0;
      rem    <= '0;
    end else if (!run) begin
      in_ext <= 1'b0;
      rem    <= base;
    end else if (rem != '0) begin
      if (tick) rem <= rem - 1'b1;
    end else if (!in_ext) begin
      in_ext <= 1'b1;
      rem    <= ext;
    end
  end
endmodule

// File: rtl/autoack_engine.sv
module autoack_engine
  import autoack_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic          cfg_ack_en,
  input  logic          cfg_promisc,
  input  logic          cfg_pend,
  input  logic [DW-1:0] cfg_base_dly,
  input  logic [DW-1:0] cfg_ext_dly,
  input  logic          rx_accept,
  input  logic [15:0]   rx_fcf,
  input  logic [7:0]    rx_seq,
  input  logic          rx_is_datareq,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          tx_start,
  input  logic          tx_done,
  output logic          pkt_sent,
  output logic          ready
);
  ack_state_e state;
  logic       want_ack, pend_now, wr_last, dly_done;
  logic [7:0] seq_q;
  logic       pend_q;

  ack_rules u_rules (
    .en(cfg_ack_en), .promisc(cfg_promisc), .pend_cfg(cfg_pend),
    .fcf(rx_fcf), .is_datareq(rx_is_datareq),
    .want_ack(want_ack), .pend(pend_now)
  );

  ack_writer #(.AW(AW)) u_writer (
    .clk(clk), .rst(rst), .go(state == ST_BUILD), .seq(seq_q), .pend(pend_q),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .last(wr_last)
  );

  ack_turnaround #(.DW(DW)) u_delay (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .tick(us_tick),
    .base(cfg_base_dly), .ext(cfg_ext_dly), .done(dly_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ready    <= 1'b1;
      tx_start <= 1'b0;
      pkt_sent <= 1'b0;
      seq_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      pkt_sent <= 1'b0;
      case (state)
        ST_IDLE: if (rx_accept && want_ack) begin
          seq_q  <= rx_seq;
          pend_q <= pend_now;
          ready  <= 1'b0;
          state  <= ST_BUILD;
        end
        ST_BUILD: if (wr_last) state <= ST_WAIT;
        ST_WAIT: if (dly_done) begin
          tx_start <= 1'b1;
          state    <= ST_TXWAIT;
        end
        default: if (tx_done) begin
          pkt_sent <= 1'b1;
          ready    <= 1'b1;
          state    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/autoack_engine_chk.sv
module autoack_engine_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_ack_en,
  input logic          cfg_promisc,
  input logic          rx_accept,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic [7:0]    buf_wdata,
  input logic          tx_start,
  input logic          tx_done,
  input logic          pkt_sent,
  input logic          ready
);
  assert_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
    ready && rx_accept && (!cfg_ack_en || cfg_promisc) |=> ready && !buf_we);

  assert_len_byte_R3: assert property (@(posedge clk) disable iff (rst)
    buf_we && (buf_addr == AW'(0)) |-> buf_wdata == 8'd5);

  assert_hi_byte_R3: assert property (@(posedge clk) disable iff (rst)
    buf_we && (buf_addr == AW'(2)) |-> buf_wdata == 8'h00);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_sent_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    pkt_sent |-> $past(tx_done) && ready);

  assert_write_busy_R8: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !ready);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> ready && !tx_start && !buf_we && !pkt_sent);
endmodule

bind autoack_engine autoack_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_ack_en(cfg_ack_en), .cfg_promisc(cfg_promisc),
  .rx_accept(rx_accept), .buf_we(buf_we), .buf_addr(buf_addr),
  .buf_wdata(buf_wdata), .tx_start(tx_start), .tx_done(tx_done),
  .pkt_sent(pkt_sent), .ready(ready)
);

// File: tb/autoack_engine_tb.sv
`timescale 1ns/1ps
module autoack_engine_tb;
  localparam int AW = 7;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b0;
  logic cfg_ack_en = 1'b1, cfg_promisc = 1'b0, cfg_pend = 1'b0;
  logic [DW-1:0] cfg_base_dly = DW'(192), cfg_ext_dly = '0;
  logic rx_accept = 1'b0;
  logic [15:0] rx_fcf = '0;
  logic [7:0] rx_seq = '0;
  logic rx_is_datareq = 1'b0;
  logic buf_we, tx_start, pkt_sent, ready;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic tx_done = 1'b0;

  always #4 clk = ~clk;

  autoack_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .cfg_ack_en(cfg_ack_en),
    .cfg_promisc(cfg_promisc), .cfg_pend(cfg_pend), .cfg_base_dly(cfg_base_dly),
    .cfg_ext_dly(cfg_ext_dly), .rx_accept(rx_accept), .rx_fcf(rx_fcf),
    .rx_seq(rx_seq), .rx_is_datareq(rx_is_datareq), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .tx_start(tx_start),
    .tx_done(tx_done), .pkt_sent(pkt_sent), .ready(ready)
  );

  int total = 0, bad = 0;
  int writes = 0, starts = 0, tick_cnt = 0, tick_seen = -1, tphase = 0;
  bit armed = 0, req = 0, inj = 0, bad_addr = 0;
  logic [7:0] mem [4];
  logic [15:0] q_fcf;
  logic [7:0] q_seq;
  logic q_dreq;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor, tick generator and accept driver share one block for a fixed order.
  always @(negedge clk) begin
    if (tx_start) begin
      starts++;
      if (armed) begin tick_seen = tick_cnt; armed = 0; end
    end
    if (buf_we) begin
      writes++;
      if (buf_addr < AW'(4)) mem[buf_addr[1:0]] = buf_wdata;
      else bad_addr = 1;
      if (buf_addr == AW'(3)) begin armed = 1; tick_cnt = 0; end
    end
    tphase = (tphase + 1) % 8;
    us_tick = (tphase == 0);
    if (us_tick && req) begin
      rx_accept = 1; rx_fcf = q_fcf; rx_seq = q_seq; rx_is_datareq = q_dreq; req = 0;
    end else if (inj) begin
      rx_accept = 1; rx_fcf = 16'h0021; rx_seq = ~q_seq; rx_is_datareq = 0; inj = 0;
    end else rx_accept = 0;
    if (armed && us_tick) tick_cnt++;
  end

  function automatic bit exp_send(bit en, bit pr, logic [15:0] f);
    return en && !pr && f[5] && (f[2:0] != 3'd0) && (f[2:0] != 3'd2);
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  // mode: 0 plain, 1 extra accept while busy, 2 extension rewritten early and late
  task automatic run_frame(input bit en, input bit pr, input bit pend,
                           input logic [15:0] f, input logic [7:0] s, input bit dreq,
                           input int base, input int ext, input int mode);
    bit send;
    int guard, exp_ext;
    logic [7:0] lo;
    step();
    cfg_ack_en = en; cfg_promisc = pr; cfg_pend = pend;
    cfg_base_dly = DW'(base); cfg_ext_dly = DW'(ext);
    writes = 0; starts = 0; tick_seen = -1; bad_addr = 0;
    for (int i = 0; i < 4; i++) mem[i] = 8'hEE;
    q_fcf = f; q_seq = s; q_dreq = dreq; req = 1;
    send = exp_send(en, pr, f);
    exp_ext = ext;
    guard = 0;
    while (req && guard < 100) begin step(); guard++; end
    if (mode == 2) begin cfg_ext_dly = DW'(ext + 2); exp_ext = ext + 2; end
    if (!send) begin
      repeat (30) step();
      chk(en && !pr ? "R2 no-ack writes" : "R1 gated writes", writes, 0);
      chk(en && !pr ? "R2 no-ack strobes" : "R1 gated strobes", starts, 0);
      chk("R1 ready stays", int'(ready), 1);
      return;
    end
    if (mode == 2) begin
      guard = 0;
      while (!(armed && tick_cnt >= base + 1) && guard < 5000) begin step(); guard++; end
      cfg_ext_dly = DW'(ext + 30);
    end
    if (mode == 1) begin
      guard = 0;
      while (writes < 4 && guard < 100) begin step(); guard++; end
      inj = 1;
    end
    guard = 0;
    while (starts == 0 && guard < 5000) begin step(); guard++; end
    step();
    chk("R8 ready low while busy", int'(ready), 0);
    lo = (pend && dreq) ? 8'h12 : 8'h02;
    chk("R3 write count", writes, 4);
    chk("R3 no stray address", int'(bad_addr), 0);
    chk("R3 length byte", int'(mem[0]), 5);
    chk("R4 fcf low byte", int'(mem[1]), int'(lo));
    chk("R3 fcf high byte", int'(mem[2]), 0);
    chk("R3 sequence byte", int'(mem[3]), int'(s));
    chk(mode == 2 ? "R6 sampled extension" : "R5 tick count", tick_seen, base + exp_ext);
    chk("R5 single strobe", starts, 1);
    repeat ($urandom_range(0, 4)) step();
    tx_done = 1; step(); tx_done = 0;
    chk("R7 pkt_sent pulse", int'(pkt_sent), 1);
    chk("R7 ready back", int'(ready), 1);
    step();
    chk("R7 pkt_sent one cycle", int'(pkt_sent), 0);
    repeat (20) step();
    chk(mode == 1 ? "R8 ignored accept writes" : "R3 no extra writes", writes, 4);
    chk(mode == 1 ? "R8 ignored accept strobe" : "R5 no extra strobe", starts, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset ready", int'(ready), 1);
    chk("R9 reset strobe", int'(tx_start), 0);
    chk("R9 reset write", int'(buf_we), 0);
    chk("R9 reset sent", int'(pkt_sent), 0);
    rst = 0;
    // default delay 192 + 0, data frame with request
    run_frame(1, 0, 0, 16'h0021, 8'h5A, 0, 192, 0, 0);
    // data-request command with pending configured
    run_frame(1, 0, 1, 16'h0023, 8'hA7, 1, 2, 1, 0);
    // pending configured but not a data request
    run_frame(1, 0, 1, 16'h0023, 8'h11, 0, 1, 0, 0);
    // zero delay both parts
    run_frame(1, 0, 0, 16'h0025, 8'hFF, 0, 0, 0, 0);
    // beacon, ack-type and no-request frames
    run_frame(1, 0, 0, 16'h0020, 8'h01, 0, 1, 1, 0);
    run_frame(1, 0, 0, 16'h0022, 8'h02, 0, 1, 1, 0);
    run_frame(1, 0, 0, 16'h0001, 8'h03, 0, 1, 1, 0);
    // gating by enable and promiscuous mode
    run_frame(0, 0, 0, 16'h0021, 8'h04, 0, 1, 1, 0);
    run_frame(1, 1, 0, 16'h0021, 8'h05, 0, 1, 1, 0);
    // busy accept ignored, extension rewritten around its capture
    run_frame(1, 0, 0, 16'h0021, 8'h66, 0, 3, 2, 1);
    run_frame(1, 0, 0, 16'h0021, 8'h77, 0, 3, 1, 2);
    for (int n = 0; n < 40; n++) begin
      logic [15:0] f;
      f = 16'($urandom());
      if ($urandom_range(0, 3) != 0) f[5] = 1'b1;
      run_frame($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
                1'($urandom()), f, 8'($urandom()), 1'($urandom()),
                $urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 2));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule